// File: doc/BRIEF.md
# I2C Multi-Message Transaction Sequencer

This block walks a list of I2C messages on top of a byte-level I2C controller, so that a whole transfer (for example a register-address write followed by a repeated-START read) runs without any CPU action per byte. The host puts the message descriptors where the sequencer can look them up by index. Each descriptor holds a 7-bit target address, a direction, a byte count and a flag that joins the message to the previous one without a new START. The host then pulses `go` with the number of messages. Bytes to be sent are pulled from a valid/ready byte stream. Bytes received are pushed out as a one-cycle-valid byte stream.

The sequencer drives the byte controller through a registered command word. It advances on each byte-complete event from the controller, using the event's received-NACK and arbitration-lost flags. Each message normally begins with a START carrying its address. Reads acknowledge every byte except the last one of a message. Any failure forces a STOP. When the STOP of a run completes, the sequencer issues a final acknowledge-only command and pulses either `fin_ok` or `fin_err`. A cycle budget aborts a run that never reaches its closing STOP.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset, `busy`, `cmd_valid`, `wr_ready`, `rd_valid`, `fin_ok` and `fin_err` are all low.
- R2: A `go` pulse while idle makes the next cycle show `busy` high and a START command for message 0. A START command has `cmd_sta`, `cmd_wr` and `cmd_iack` set, and `cmd_data` holds the address in bits 7:1 and the read flag in bit 0.
- R3: Write bytes are taken from the stream in order, one per handshake (`wr_valid` and `wr_ready` both high). The next cycle shows a write command (`cmd_wr` and `cmd_iack` set, `cmd_sta` clear) carrying that byte. A byte is requested only after the previous event of the message completed without a NACK.
- R4: Each completion event of a read command emits the received byte on `rd_data` with `rd_valid` high for one cycle. A read command has `cmd_rd` set, and its `cmd_nack` is set only for the final byte of a message.
- R5: When a message ends and another remains, the next message starts with a new START carrying its own address. If that message has the no-start flag, its data bytes follow directly with no START and no address.
- R6: A message of length zero finishes as soon as its address byte completes, and no data command is issued for it.
- R7: A received NACK on the event of an address or write byte leads to a STOP command (`cmd_sto` and `cmd_iack` set), and the run ends with `fin_err`. A NACK flag on a read event has no effect.
- R8: Arbitration lost on any event other than the one that completes the closing STOP leads to a STOP command and a `fin_err` ending. On a read event, no byte is emitted.
- R9: After the last message, a STOP is issued. When that STOP completes, an acknowledge-only command (only `cmd_iack` set) is issued together with exactly one pulse of `fin_ok`, or of `fin_err` if the run had failed, and `busy` falls.
- R10: When `timeout_cycles` is nonzero and the run has not reached its closing STOP within about that many cycles after `go`, the run ends with `fin_err`, and no further command is issued.
- R11: A `go` pulse while `busy` is high has no effect on the commands issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start a run (ignored while busy) |
| msg_count | input | IDX_W | Number of messages in the run (at least 1) |
| timeout_cycles | input | TO_W | Cycle budget for a run, 0 disables it |
| desc_idx | output | IDX_W | Index of the descriptor being looked up |
| desc_addr | input | 7 | Target address of the indexed message |
| desc_rd | input | 1 | Indexed message is a read |
| desc_len | input | LEN_W | Byte count of the indexed message |
| desc_nostart | input | 1 | Indexed message joins the previous one without START |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte available |
| wr_ready | output | 1 | Sequencer takes the write byte this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte valid (one cycle) |
| cmd_valid | output | 1 | Command valid (one cycle) |
| cmd_sta | output | 1 | Generate START before the byte |
| cmd_sto | output | 1 | Generate STOP |
| cmd_rd | output | 1 | Read one byte |
| cmd_wr | output | 1 | Write `cmd_data` |
| cmd_nack | output | 1 | Answer the read byte with NACK |
| cmd_iack | output | 1 | Acknowledge the previous completion event |
| cmd_data | output | 8 | Byte to send |
| evt_done | input | 1 | Byte controller finished the last command |
| evt_nack | input | 1 | Target answered NACK |
| evt_arb | input | 1 | Arbitration lost |
| evt_rx | input | 8 | Byte received by a read command |
| busy | output | 1 | A run is in progress |
| fin_ok | output | 1 | Run completed successfully (pulse) |
| fin_err | output | 1 | Run ended with an error (pulse) |

## Verification
The hardest situations to reach from the ports are a failure flag arriving on one particular event: a NACK on a data byte deep inside a message, an arbitration loss on a read byte, or either flag on the completion of the closing STOP, where it must be ignored. The bench models the byte controller with random response delays and numbers every completion event it produces. Each run names the event index that carries a NACK or arbitration-lost flag, so directed runs place a failure at an exact point and random runs scatter it over address, data, read and STOP events. A stalled controller that never answers drives the run into the cycle budget.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  // Transfer state of the running sequence
  typedef enum logic [2:0] {
    S_DONE,
    S_START,
    S_WRITE,
    S_READ,
    S_ERROR
  } xfer_st_e;

  // Internal phase of the walker
  typedef enum logic [1:0] {
    P_IDLE,   // no run
    P_WAIT,   // command issued, waiting for completion event
    P_NEXT,   // message boundary: look at next descriptor
    P_WDATA   // waiting for a byte on the write stream
  } phase_e;

  // Command request to the output register
  typedef enum logic [2:0] {
    K_NONE,
    K_START,
    K_WRITE,
    K_READ,
    K_STOP,
    K_ACK
  } cmd_kind_e;

endpackage

// File: rtl/i2cseq_cmd_out.sv
module i2cseq_cmd_out
  import i2cseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cmd_kind_e  kind,
  input  logic       nack,
  input  logic [7:0] data,
  output logic       cmd_valid,
  output logic       cmd_sta,
  output logic       cmd_sto,
  output logic       cmd_rd,
  output logic       cmd_wr,
  output logic       cmd_nack,
  output logic       cmd_iack,
  output logic [7:0] cmd_data
);

  logic carries_byte;
  assign carries_byte = (kind == K_START) || (kind == K_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_sta   <= 1'b0;
      cmd_sto   <= 1'b0;
      cmd_rd    <= 1'b0;
      cmd_wr    <= 1'b0;
      cmd_nack  <= 1'b0;
      cmd_iack  <= 1'b0;
      cmd_data  <= 8'h00;
    end else begin
      cmd_valid <= (kind != K_NONE);
      cmd_sta   <= (kind == K_START);
      cmd_sto   <= (kind == K_STOP);
      cmd_rd    <= (kind == K_READ);
      cmd_wr    <= carries_byte;
      cmd_nack  <= (kind == K_READ) && nack;
      // every command also clears the pending completion event
      cmd_iack  <= (kind != K_NONE);
      cmd_data  <= carries_byte ? data : 8'h00;
    end
  end

endmodule

// File: rtl/i2cseq_budget.sv
module i2cseq_budget #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            expire
);

  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != {TO_W{1'b1}}) cnt <= cnt + TO_W'(1);
  end

  assign expire = run && (limit != '0) && (cnt >= limit);

  // R10: the owner aborts the run once the budget is used, so the count never overshoots
  a_r10_count_bounded: assert property (@(posedge clk) disable iff (rst)
    (run && limit != '0 && $stable(limit)) |-> (cnt <= limit));

endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import i2cseq_pkg::*;
#(
  parameter int MAX_MSGS = 8,
  parameter int LEN_W    = 8,
  parameter int TO_W     = 16,
  localparam int IDX_W   = $clog2(MAX_MSGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [IDX_W-1:0] msg_count,
  input  logic [TO_W-1:0]  timeout_cycles,
  output logic [IDX_W-1:0] desc_idx,
  input  logic [6:0]       desc_addr,
  input  logic             desc_rd,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             desc_nostart,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             cmd_valid,
  output logic             cmd_sta,
  output logic             cmd_sto,
  output logic             cmd_rd,
  output logic             cmd_wr,
  output logic             cmd_nack,
  output logic             cmd_iack,
  output logic [7:0]       cmd_data,
  input  logic             evt_done,
  input  logic             evt_nack,
  input  logic             evt_arb,
  input  logic [7:0]       evt_rx,
  output logic             busy,
  output logic             fin_ok,
  output logic             fin_err
);

  xfer_st_e         pst, pst_n;
  phase_e           ph, ph_n;
  logic [IDX_W-1:0] idx, idx_n;
  logic [LEN_W-1:0] pos, pos_n, pos_t;
  logic             ok_n, err_n, rdv_n, cont;
  logic [7:0]       rdd_n;
  cmd_kind_e        req;
  logic             rq_nack;
  logic [7:0]       rq_data;
  logic             run, tmo;
  xfer_st_e         dir_st;

  assign dir_st   = desc_rd ? S_READ : S_WRITE;
  assign desc_idx = idx;
  assign busy     = (ph != P_IDLE);
  assign wr_ready = (ph == P_WDATA) && !tmo;
  assign run      = (ph != P_IDLE) && (pst != S_DONE) && (pst != S_ERROR);

  i2cseq_budget #(.TO_W(TO_W)) u_budget (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .limit  (timeout_cycles),
    .expire (tmo)
  );

  always_comb begin
    pst_n   = pst;
    ph_n    = ph;
    idx_n   = idx;
    pos_n   = pos;
    pos_t   = pos;
    req     = K_NONE;
    rq_nack = 1'b0;
    rq_data = 8'h00;
    ok_n    = 1'b0;
    err_n   = 1'b0;
    rdv_n   = 1'b0;
    rdd_n   = rd_data;
    cont    = 1'b0;

    unique case (ph)
      P_IDLE: begin
        if (go) begin
          pst_n   = S_START;
          ph_n    = P_WAIT;
          pos_n   = '0;
          req     = K_START;
          rq_data = {desc_addr, desc_rd};
        end
      end
      P_WAIT: begin
        if (evt_done) begin
          if (pst == S_DONE || pst == S_ERROR) begin
            // closing STOP has completed
            req   = K_ACK;
            ph_n  = P_IDLE;
            idx_n = '0;
            ok_n  = (pst == S_DONE);
            err_n = (pst == S_ERROR);
          end else if (evt_arb) begin
            pst_n = S_ERROR;
            req   = K_STOP;
          end else if (pst == S_START || pst == S_WRITE) begin
            if (evt_nack) begin
              pst_n = S_ERROR;
              req   = K_STOP;
            end else begin
              pst_n = dir_st;
              cont  = 1'b1;
            end
          end else begin
            rdv_n = 1'b1;
            rdd_n = evt_rx;
            pos_t = pos + LEN_W'(1);
            cont  = 1'b1;
          end
        end
      end
      P_NEXT: begin
        if (idx == msg_count) begin
          pst_n = S_DONE;
          req   = K_STOP;
          ph_n  = P_WAIT;
        end else if (!desc_nostart) begin
          pst_n   = S_START;
          req     = K_START;
          rq_data = {desc_addr, desc_rd};
          ph_n    = P_WAIT;
        end else begin
          pst_n = dir_st;
          pos_t = '0;
          cont  = 1'b1;
        end
      end
      P_WDATA: begin
        if (wr_valid) begin
          req     = K_WRITE;
          rq_data = wr_data;
          pos_n   = pos + LEN_W'(1);
          ph_n    = P_WAIT;
        end
      end
    endcase

    // shared continuation: end of message, or next data command
    if (cont) begin
      pos_n = pos_t;
      if (pos_t == desc_len) begin
        ph_n  = P_NEXT;
        idx_n = idx + IDX_W'(1);
        pos_n = '0;
      end else if (pst_n == S_READ) begin
        req     = K_READ;
        rq_nack = ((pos_t + LEN_W'(1)) == desc_len);
        ph_n    = P_WAIT;
      end else begin
        ph_n = P_WDATA;
      end
    end

    // cycle budget overrides everything
    if (tmo) begin
      pst_n = S_ERROR;
      ph_n  = P_IDLE;
      idx_n = '0;
      pos_n = '0;
      req   = K_NONE;
      ok_n  = 1'b0;
      err_n = 1'b1;
      rdv_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pst      <= S_DONE;
      ph       <= P_IDLE;
      idx      <= '0;
      pos      <= '0;
      fin_ok   <= 1'b0;
      fin_err  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      pst      <= pst_n;
      ph       <= ph_n;
      idx      <= idx_n;
      pos      <= pos_n;
      fin_ok   <= ok_n;
      fin_err  <= err_n;
      rd_valid <= rdv_n;
      rd_data  <= rdd_n;
    end
  end

  i2cseq_cmd_out u_cmd (
    .clk       (clk),
    .rst       (rst),
    .kind      (req),
    .nack      (rq_nack),
    .data      (rq_data),
    .cmd_valid (cmd_valid),
    .cmd_sta   (cmd_sta),
    .cmd_sto   (cmd_sto),
    .cmd_rd    (cmd_rd),
    .cmd_wr    (cmd_wr),
    .cmd_nack  (cmd_nack),
    .cmd_iack  (cmd_iack),
    .cmd_data  (cmd_data)
  );

  // R2: a run begins with a START and raises busy
  a_r2_go_starts: assert property (@(posedge clk) disable iff (rst)
    (!busy && go) |=> (busy && cmd_valid && cmd_sta && cmd_wr));

  // R3: a stream handshake turns into a write command next cycle
  a_r3_pop_writes: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && wr_valid) |=> (cmd_valid && cmd_wr && !cmd_sta));

  // R4: a clean read event emits the byte
  a_r4_read_emits: assert property (@(posedge clk) disable iff (rst)
    (ph == P_WAIT && pst == S_READ && evt_done && !evt_arb && !tmo)
    |=> (rd_valid && rd_data == $past(evt_rx)));

  // R7: NACK after address or write byte forces STOP
  a_r7_nack_stops: assert property (@(posedge clk) disable iff (rst)
    (ph == P_WAIT && evt_done && evt_nack && !evt_arb && !tmo &&
     (pst == S_START || pst == S_WRITE)) |=> (cmd_valid && cmd_sto));

  // R8: arbitration loss before the closing STOP forces STOP
  a_r8_arb_stops: assert property (@(posedge clk) disable iff (rst)
    (ph == P_WAIT && evt_done && evt_arb && !tmo &&
     pst != S_DONE && pst != S_ERROR) |=> (cmd_valid && cmd_sto && !rd_valid));

  // R9: a finish pulse leaves the block idle and never reports both results
  a_r9_fin_idle: assert property (@(posedge clk) disable iff (rst)
    (fin_ok || fin_err) |-> (!busy && !(fin_ok && fin_err)));

endmodule

// File: tb/i2c_msg_seq_test.sv
module i2c_msg_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int IDXW = 4;
  localparam int LENW = 8;
  localparam int TOW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic [IDXW-1:0] msg_count = 4'd1;
  logic [TOW-1:0]  tmo_lim = 16'd2000;
  logic [IDXW-1:0] desc_idx;
  logic [6:0] desc_addr;
  logic desc_rd, desc_nostart;
  logic [LENW-1:0] desc_len;
  logic [7:0] wr_data = 8'h00;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [7:0] rd_data;
  logic rd_valid;
  logic cmd_valid, cmd_sta, cmd_sto, cmd_rd, cmd_wr, cmd_nack, cmd_iack;
  logic [7:0] cmd_data;
  logic evt_done = 1'b0, evt_nack = 1'b0, evt_arb = 1'b0;
  logic [7:0] evt_rx = 8'h00;
  logic busy, fin_ok, fin_err;

  // message table and write bytes
  logic [6:0] m_addr [0:15];
  logic       m_rd   [0:15];
  logic [7:0] m_len  [0:15];
  logic       m_ns   [0:15];
  logic [7:0] wb     [0:63];

  assign desc_addr    = m_addr[desc_idx];
  assign desc_rd      = m_rd[desc_idx];
  assign desc_len     = m_len[desc_idx];
  assign desc_nostart = m_ns[desc_idx];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nack_at = -1, arb_at = -1, ev_no = -1, dly = 0;
  bit hang = 0, last_rd = 0, pop_pend = 0;
  int wptr = 0;
  int obs_q[$], exp_q[$], rx_q[$], rd_q[$];
  bit exp_ok;

  i2c_msg_seq #(.MAX_MSGS(8), .LEN_W(LENW), .TO_W(TOW)) uut (
    .clk(clk), .rst(rst), .go(go), .msg_count(msg_count), .timeout_cycles(tmo_lim),
    .desc_idx(desc_idx), .desc_addr(desc_addr), .desc_rd(desc_rd), .desc_len(desc_len),
    .desc_nostart(desc_nostart), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .cmd_valid(cmd_valid), .cmd_sta(cmd_sta),
    .cmd_sto(cmd_sto), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_nack(cmd_nack),
    .cmd_iack(cmd_iack), .cmd_data(cmd_data), .evt_done(evt_done), .evt_nack(evt_nack),
    .evt_arb(evt_arb), .evt_rx(evt_rx), .busy(busy), .fin_ok(fin_ok), .fin_err(fin_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // byte controller model: logs commands, answers with numbered events
  always @(negedge clk) begin
    evt_done = 1'b0;
    evt_nack = 1'b0;
    evt_arb  = 1'b0;
    if (dly > 0) begin
      dly--;
      if (dly == 0) begin
        ev_no++;
        evt_done = 1'b1;
        evt_nack = (ev_no == nack_at);
        evt_arb  = (ev_no == arb_at);
        evt_rx   = 8'($urandom);
        if (last_rd && !evt_arb) rx_q.push_back(int'(evt_rx));
      end
    end
    if (cmd_valid) begin
      obs_q.push_back(int'({cmd_sta, cmd_sto, cmd_rd, cmd_wr, cmd_nack, cmd_iack}) * 256
                      + int'(cmd_data));
      last_rd = cmd_rd;
      if (!hang && (cmd_sta || cmd_sto || cmd_rd || cmd_wr)) dly = 1 + int'($urandom % 4);
    end
  end

  // write stream source and read stream sink
  always @(negedge clk) begin
    if (pop_pend) wptr++;
    wr_valid = ($urandom % 4) != 0;
    wr_data  = wb[wptr % 64];
    pop_pend = wr_valid && wr_ready;
    if (rd_valid) rd_q.push_back(int'(rd_data));
  end

  function automatic int enc(bit sta, bit sto, bit rd, bit wr, bit nk, int data);
    return int'({sta, sto, rd, wr, nk, 1'b1}) * 256 + data;
  endfunction

  // expected command list from the requirements
  task automatic build_expected(int n);
    int st, i, p, ev, w;
    bit adv, issued;
    // st: 0 done, 1 start, 2 write, 3 read, 4 error
    exp_q.delete();
    st = 1; i = 0; p = 0; ev = 0; w = 0;
    exp_q.push_back(enc(1, 0, 0, 1, 0, int'({m_addr[0], m_rd[0]})));
    for (int g = 0; g < 400; g++) begin
      issued = 0;
      if (st == 0 || st == 4) begin
        exp_q.push_back(256);
        exp_ok = (st == 0);
        return;
      end
      if (ev == arb_at) begin
        st = 4; exp_q.push_back(enc(0, 1, 0, 0, 0, 0)); ev++; continue;
      end
      if (st == 1 || st == 2) begin
        if (ev == nack_at) begin
          st = 4; exp_q.push_back(enc(0, 1, 0, 0, 0, 0)); ev++; continue;
        end
        st = m_rd[i] ? 3 : 2;
      end else p++;
      ev++;
      adv = 1;
      while (adv) begin
        if (p == int'(m_len[i])) begin
          i++; p = 0;
          if (i == n) begin
            st = 0; exp_q.push_back(enc(0, 1, 0, 0, 0, 0)); adv = 0; issued = 1;
          end else if (!m_ns[i]) begin
            st = 1; exp_q.push_back(enc(1, 0, 0, 1, 0, int'({m_addr[i], m_rd[i]})));
            adv = 0; issued = 1;
          end else st = m_rd[i] ? 3 : 2;
        end else adv = 0;
      end
      if (!issued) begin
        if (st == 3) exp_q.push_back(enc(0, 0, 1, 0, (p + 1 == int'(m_len[i])), 0));
        else begin
          exp_q.push_back(enc(0, 0, 0, 1, 0, int'(wb[w])));
          w++; p++;
        end
      end
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_q(string tag, string what, ref int a[$], ref int e[$]);
    int bad = -1;
    checks++;
    if (a.size() != e.size()) begin
      errors++;
      $display("FAIL %s %s length: actual %0d expected %0d", tag, what, a.size(), e.size());
      return;
    end
    foreach (a[k]) if (bad < 0 && a[k] != e[k]) bad = k;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s %s entry %0d: actual %0h expected %0h", tag, what, bad, a[bad], e[bad]);
    end
  endtask

  task automatic set_msg(int k, int addr, bit rd, int len, bit ns);
    m_addr[k] = 7'(addr);
    m_rd[k]   = rd;
    m_len[k]  = 8'(len);
    m_ns[k]   = ns;
  endtask

  task automatic run_case(string tag, int n, int nk, int ab, bit extra_go);
    int oks = 0, errs = 0;
    bit fin = 0;
    msg_count = IDXW'(n);
    nack_at = nk;
    arb_at  = ab;
    ev_no   = -1;
    wptr    = 0;
    obs_q.delete(); rx_q.delete(); rd_q.delete();
    for (int k = 0; k < 64; k++) wb[k] = 8'($urandom);
    build_expected(n);
    @(negedge clk);
    go = 1'b1;
    for (int c = 0; c < 3000 && !fin; c++) begin
      @(negedge clk);
      go = (extra_go && c == 6);
      if (fin_ok || fin_err) begin
        fin = 1; oks += int'(fin_ok); errs += int'(fin_err);
      end
    end
    go = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      oks += int'(fin_ok); errs += int'(fin_err);
    end
    chk_q(tag, "command list", obs_q, exp_q);
    chk_q(tag, "read stream (R4)", rd_q, rx_q);
    chk(tag, "R9 ok pulses", oks, exp_ok ? 1 : 0);
    chk(tag, "R9 err pulses", errs, exp_ok ? 0 : 1);
  endtask

  initial begin
    int n, t0, waited;
    void'($urandom(32'd5150));
    for (int k = 0; k < 16; k++) set_msg(k, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "cmd_valid", int'(cmd_valid), 0);
    chk("R1", "wr_ready/rd_valid", int'(wr_ready) + int'(rd_valid), 0);
    chk("R1", "fin", int'(fin_ok) + int'(fin_err), 0);

    // R2 R3: single write; R11: extra go mid-run is ignored
    set_msg(0, 7'h50, 0, 3, 0);
    run_case("R2_R3_R11", 1, -1, -1, 1);
    chk("R2", "first command is START addr 0x50 write", obs_q.size() > 0 ? obs_q[0] : -1,
        enc(1, 0, 0, 1, 0, 8'hA0));

    // R4 R5: write then repeated-START read of 3, NACK on last byte only
    set_msg(0, 7'h21, 0, 1, 0);
    set_msg(1, 7'h21, 1, 3, 0);
    run_case("R4_R5", 2, -1, -1, 0);

    // R4: single-byte read is NACKed at once
    set_msg(0, 7'h33, 1, 1, 0);
    run_case("R4", 1, -1, -1, 0);

    // R5: no-start continuation of a write
    set_msg(0, 7'h44, 0, 2, 0);
    set_msg(1, 7'h44, 0, 2, 1);
    run_case("R5", 2, -1, -1, 0);

    // R6: zero-length probe then read of 2
    set_msg(0, 7'h12, 0, 0, 0);
    set_msg(1, 7'h13, 1, 2, 0);
    run_case("R6", 2, -1, -1, 0);

    // R7: address NACK
    set_msg(0, 7'h60, 0, 2, 0);
    run_case("R7", 1, 0, -1, 0);
    // R7: data NACK on second write byte
    run_case("R7", 1, 2, -1, 0);
    // R7: NACK flag on a read event has no effect
    set_msg(0, 7'h61, 1, 3, 0);
    run_case("R7", 1, 2, -1, 0);

    // R8: arbitration lost on a read byte
    set_msg(0, 7'h62, 1, 3, 0);
    run_case("R8", 1, -1, 2, 0);
    // R8 R9: flags on the closing STOP completion are ignored
    set_msg(0, 7'h63, 0, 1, 0);
    run_case("R8_R9", 1, 2, 2, 0);

    // R10: controller never answers
    set_msg(0, 7'h70, 0, 1, 0);
    msg_count = 4'd1;
    hang = 1; tmo_lim = 16'd40;
    obs_q.delete();
    @(negedge clk);
    go = 1'b1;
    t0 = cyc;
    @(negedge clk);
    go = 1'b0;
    waited = 0;
    while (!fin_ok && !fin_err && waited < 500) begin
      @(negedge clk);
      waited++;
    end
    chk("R10", "err result", int'(fin_err), 1);
    chk("R10", "cycles within budget window", int'((cyc - t0) >= 40 && (cyc - t0) <= 43), 1);
    repeat (4) @(negedge clk);
    chk("R10", "only the START was issued", obs_q.size(), 1);
    hang = 0; tmo_lim = 16'd2000; dly = 0;
    repeat (2) @(negedge clk);

    // random runs covering R3..R9
    for (int r = 0; r < 24; r++) begin
      n = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++)
        set_msg(k, int'($urandom % 128), bit'($urandom % 2), int'($urandom % 5),
                (k > 0) && ($urandom % 4 == 0));
      run_case("R3_R4_R5_R6_R7_R8_rand", n,
               ($urandom % 3 == 0) ? int'($urandom % 8) : -1,
               ($urandom % 5 == 0) ? int'($urandom % 8) : -1, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule